// File: doc/BRIEF.md
# Prescaled Event Timer with Restart Control

This block is an 8-bit up-counter whose counting rate comes from a programmable prescaler. A free-running 10-bit divider of the system clock supplies seven taps. A select field in a mode register picks one of these taps, or picks a synchronized external event input, as the source of single-cycle count enables. All logic runs on the one system clock.

Software controls the timer through a single mode register, which has a write strobe and a parallel read-back. The start field restarts the counter from zero only when it changes from 0 to 1. Rewriting it as 1 leaves the count alone. A separate continue field pauses and resumes the count without clearing it. When capture is enabled, a rising edge on the capture input stores the live count in a capture register. Each time the count wraps from its maximum value back to zero, a one-cycle tick output fires.

Top module: `tick_timer`

## Requirements
- R1: The mode register has these fields: bit 5 is capture enable, bits 4:2 are the source select, bit 1 is continue and bit 0 is start. Bits 7:6 always read back as 0, even after a write of 0xFF, which then reads 0x3F.
- R2: After reset, the mode readback, count and capture value are all 0, and the wrap tick is low.
- R3: Source select codes 000, 001, 010, 011, 100, 101 and 110 advance a running count once every 2, 4, 8, 32, 128, 512 and 1024 clock cycles respectively.
- R4: With source select 111, each rising edge of `evtIn` advances a running count by exactly one.
- R5: Writing start = 0 stops counting, so later events leave the count unchanged.
- R6: A write that changes start from 0 to 1 clears the count to 0, and counting then proceeds from 0.
- R7: A write of start = 1 while start is already 1 does not clear the count, and counting continues from the held value.
- R8: Counting happens only when both start and continue are 1. With continue = 0 the count is held. Setting continue back to 1 resumes from the held value without clearing it.
- R9: An advance from 255 wraps the count to 0, and `wrapTick` is high for that single cycle only.
- R10: With capture enable = 1, a rising edge on `capIn` copies the current count into `capOut`.
- R11: With capture enable = 0, edges on `capIn` leave `capOut` unchanged.
- R12: When a capture and a count advance fall in the same cycle, `capOut` receives the count as it was before the advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 8 | Mode register write data |
| modeRdata | output | 8 | Mode register readback |
| evtIn | input | 1 | External event input, synchronized inside the block |
| capIn | input | 1 | Capture trigger input, synchronized inside the block |
| countOut | output | 8 | Current count |
| capOut | output | 8 | Last captured count |
| wrapTick | output | 1 | One-cycle pulse on wrap from 255 to 0 |

## Verification
The capture strobe and the count advance can fall in the same cycle. The bench provokes this by raising `evtIn` and `capIn` on the same clock phase. Both pass through synchronizers of equal depth, so their internal strobes meet on one edge. The case is judged correct when `capOut` holds the count from before that edge and `countOut` shows the incremented value.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int MODE_W    = 8;
  localparam int START_BIT = 0;
  localparam int CONT_BIT  = 1;
  localparam int SEL_LO    = 2;
  localparam int SEL_HI    = 4;
  localparam int CAPEN_BIT = 5;
  localparam int FIELD_W   = CAPEN_BIT + 1;
  localparam int NUM_TAPS  = 7;
  localparam logic [2:0] SEL_EVENT = 3'b111;

  typedef struct packed {
    logic clr;
    logic inc;
    logic cap;
  } tmr_strobe_t;

  // Prescaler bit whose rising transition forms the enable for a select code
  function automatic int tap_bit(input int code);
    case (code)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 4;
      4:       return 6;
      5:       return 8;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PRE_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWdata,
  output logic [MODE_W-1:0] modeRdata,
  input  logic              evtIn,
  input  logic              capIn,
  output tmr_strobe_t       strb
);

  logic [FIELD_W-1:0] modeQ;
  logic [PRE_W-1:0]   preQ;
  logic [SYNC_N-1:0]  evtSync;
  logic [SYNC_N-1:0]  capSync;
  logic               capPrev;
  logic               srcPrev;
  logic [7:0]         srcVec;
  logic               srcNow;
  logic               tickEn;
  logic               capRise;
  logic               startRise;
  logic               running;
  logic [2:0]         clkSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       modeQ <= '0;
    else if (modeWe) modeQ <= modeWdata[FIELD_W-1:0];
  end

  assign modeRdata = {{(MODE_W-FIELD_W){1'b0}}, modeQ};
  assign clkSel    = modeQ[SEL_HI:SEL_LO];
  assign running   = modeQ[START_BIT] & modeQ[CONT_BIT];
  assign startRise = modeWe & modeWdata[START_BIT] & ~modeQ[START_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preQ <= '0;
    else       preQ <= preQ + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtSync <= '0;
      capSync <= '0;
      capPrev <= 1'b0;
      srcPrev <= 1'b0;
    end else begin
      evtSync <= {evtSync[SYNC_N-2:0], evtIn};
      capSync <= {capSync[SYNC_N-2:0], capIn};
      capPrev <= capSync[SYNC_N-1];
      srcPrev <= srcNow;
    end
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int TB = tap_bit(i);
    assign srcVec[i] = preQ[TB];
  end
  assign srcVec[7] = evtSync[SYNC_N-1];

  assign srcNow  = srcVec[clkSel];
  assign tickEn  = srcNow & ~srcPrev;
  assign capRise = capSync[SYNC_N-1] & ~capPrev;

  assign strb.clr = startRise;
  assign strb.inc = tickEn & running;
  assign strb.cap = capRise & modeQ[CAPEN_BIT];

  // R3: enables never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> !tickEn);

  // R5: a write of start = 0 blocks advances in the following cycle
  p_stop_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && !modeWdata[START_BIT]) |=> !strb.inc);

  // R8: a write of continue = 0 blocks advances in the following cycle
  p_hold_cont_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && !modeWdata[CONT_BIT]) |=> !strb.inc);

  // R7: rewriting start as 1 while it reads 1 never clears
  p_no_clear_rewrite_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && modeRdata[START_BIT]) |-> !strb.clr);

  // R11: no capture while capture enable reads 0
  p_cap_gated_r11: assert property (@(posedge clk) disable iff (!rstN)
    !modeRdata[CAPEN_BIT] |-> !strb.cap);

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  output logic [CNT_W-1:0] countOut,
  output logic [CNT_W-1:0] capOut,
  output logic             wrapTick
);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] capQ;
  logic             wrapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      capQ   <= '0;
      wrapQ  <= 1'b0;
    end else begin
      wrapQ <= 1'b0;
      if (strb.clr) begin
        countQ <= '0;
      end else if (strb.inc) begin
        countQ <= countQ + CNT_W'(1);
        wrapQ  <= &countQ;
      end
      if (strb.cap) capQ <= countQ;
    end
  end

  assign countOut = countQ;
  assign capOut   = capQ;
  assign wrapTick = wrapQ;

  // R6: a restart strobe leaves the count at zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (countOut == '0));

  // R4: an advance moves the count by exactly one
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clr && strb.inc) |=> (countOut == $past(countOut) + CNT_W'(1)));

  // R5: without clear or advance the count holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clr && !strb.inc) |=> $stable(countOut));

  // R9: the wrap tick appears only with a zero count
  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrapTick |-> (countOut == '0));

  // R9: the wrap tick lasts a single cycle
  p_wrap_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrapTick |=> !wrapTick);

  // R12: a capture stores the count seen before that edge
  p_capture_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.cap |=> (capOut == $past(countOut)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWdata,
  output logic [MODE_W-1:0] modeRdata,
  input  logic              evtIn,
  input  logic              capIn,
  output logic [CNT_W-1:0]  countOut,
  output logic [CNT_W-1:0]  capOut,
  output logic              wrapTick
);

  tmr_strobe_t strb;

  tick_timer_ctrl #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeWe    (modeWe),
    .modeWdata (modeWdata),
    .modeRdata (modeRdata),
    .evtIn     (evtIn),
    .capIn     (capIn),
    .strb      (strb)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .countOut (countOut),
    .capOut   (capOut),
    .wrapTick (wrapTick)
  );

endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWe = 1'b0;
  logic [7:0] modeWdata = 8'h00;
  logic [7:0] modeRdata;
  logic       evtIn = 1'b0;
  logic       capIn = 1'b0;
  logic [7:0] countOut;
  logic [7:0] capOut;
  logic       wrapTick;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int wrapCnt = 0;
  bit done    = 1'b0;

  // {select code, expected cycles between advances}
  localparam logic [15:0] VEC [7] = '{
    {3'd0, 13'd2},   {3'd1, 13'd4},   {3'd2, 13'd8},   {3'd3, 13'd32},
    {3'd4, 13'd128}, {3'd5, 13'd512}, {3'd6, 13'd1024}
  };

  always #10 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWdata(modeWdata),
    .modeRdata(modeRdata), .evtIn(evtIn), .capIn(capIn),
    .countOut(countOut), .capOut(capOut), .wrapTick(wrapTick)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wrapTick) wrapCnt <= wrapCnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrMode(input logic [7:0] v);
    @(negedge clk);
    modeWe = 1'b1;
    modeWdata = v;
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  task automatic pulse(input bit ev, input bit cp);
    @(negedge clk);
    evtIn = ev;
    capIn = cp;
    repeat (2) @(negedge clk);
    evtIn = 1'b0;
    capIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitChange(output int t);
    logic [7:0] prev;
    prev = countOut;
    t = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (countOut != prev) begin
        t = cyc;
        break;
      end
    end
  endtask

  initial begin
    int t1, t2, base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 mode", modeRdata, 0);
    chk("R2 count", countOut, 0);
    chk("R2 capture", capOut, 0);
    chk("R2 tick", wrapTick, 0);

    // R3: prescaler periods
    for (int i = 0; i < 7; i++) begin
      wrMode({3'b000, VEC[i][15:13], 2'b00});
      wrMode({3'b000, VEC[i][15:13], 2'b11});
      waitChange(t1);
      waitChange(t2);
      chk($sformatf("R3 code %0d period", VEC[i][15:13]),
          (t1 < 0 || t2 < 0) ? -1 : t2 - t1, int'(VEC[i][12:0]));
    end

    // R6 / R4: restart then count events
    wrMode(8'h1C);
    wrMode(8'h1F);
    @(negedge clk);
    chk("R6 clear on start rise", countOut, 0);
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    chk("R4 five events", countOut, 5);

    // R7: rewrite start as 1
    wrMode(8'h1F);
    @(negedge clk);
    chk("R7 no clear on rewrite", countOut, 5);
    pulse(1'b1, 1'b0);
    chk("R7 keeps counting", countOut, 6);

    // R8: continue gating
    wrMode(8'h1D);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R8 held with continue 0", countOut, 6);
    wrMode(8'h1F);
    @(negedge clk);
    chk("R8 resume keeps value", countOut, 6);
    pulse(1'b1, 1'b0);
    chk("R8 resumes counting", countOut, 7);

    // R5 / R6: stop and restart
    wrMode(8'h1E);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R5 stopped", countOut, 7);
    wrMode(8'h1F);
    @(negedge clk);
    chk("R6 restart clears", countOut, 0);

    // R10 / R11: capture
    wrMode(8'h3F);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    chk("R10 capture value", capOut, 3);
    chk("R10 count unaffected", countOut, 3);
    wrMode(8'h1F);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    chk("R11 capture ignored", capOut, 3);

    // R12: simultaneous capture and advance
    wrMode(8'h3F);
    pulse(1'b1, 1'b1);
    chk("R12 count advanced", countOut, 5);
    chk("R12 pre-advance captured", capOut, 4);

    // R9: wrap
    wrMode(8'h1C);
    wrMode(8'h1F);
    base = wrapCnt;
    for (int i = 0; i < 255; i++) pulse(1'b1, 1'b0);
    chk("R9 at maximum", countOut, 255);
    chk("R9 no early tick", wrapCnt - base, 0);
    pulse(1'b1, 1'b0);
    chk("R9 wrapped to zero", countOut, 0);
    chk("R9 single tick", wrapCnt - base, 1);

    // R1: reserved bits
    wrMode(8'hFF);
    @(negedge clk);
    chk("R1 readback", modeRdata, 8'h3F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule